// File: doc/BRIEF.md
# Nonvolatile Store Sequencer with Busy Flag

This block decides whether a channel setting just received by a serial front end is committed to a nonvolatile store. It then runs the erase/write cycle as a fixed count of clocks. The store is modelled as a register array with one entry per output channel. A power-on reset fills the array with a default code. A later logic reset leaves the array alone.

The front end reports the start bit of a frame with `frame_start`. It hands over the complete frame, meaning the channel address and the 8-bit value, on a valid/ready channel. A store is requested by raising `prog_en` inside a short window tied to that frame. If no request arrives, the value is dropped. While a store runs, the block pulls its active-low ready/busy flag low and raises `hold`, which tells the front end to ignore its data input and leave its data output idle. The flag is gated by a supply-ok input, so a weak supply shows as a flag that never goes low. After every logic reset, the block copies each stored entry into its live setting, one channel per clock. No frame is needed for this.

Frame handshake rules: a frame is taken on a clock edge where `frame_valid` and `frame_ready` are both high. A frame offered while `frame_ready` is low is not stored and not queued. The front end must not rely on it being kept. `frame_ready` falls for two clocks after every accepted frame. It also stays low for as long as `hold` is high.

Top module: `nv_store_seq`

## Requirements
- R1: After `rst_n` is released, `hold` stays high for NUM_CH clocks while the live settings are reloaded. Then each channel of `live_codes` equals its store entry. Channel i sits at bits [i*DW +: DW]. After a power-on reset every entry holds INIT_CODE (default 0x80).
- R2: A store is requested when `prog_en` is sampled high on any clock edge after the start-bit edge, up to and including the edge that follows frame acceptance. The `frame_addr` value 0..3 selects the channel in binary.
- R3: In these cases no store happens, `rdy_busy_n` stays high, and the value is discarded: `prog_en` is high only on or before the start-bit edge, or it first rises on the second edge after acceptance.
- R4: `frame_ready` is low during the two clocks after an accepted frame. It returns high on the second edge after acceptance when no store was requested.
- R5: `rdy_busy_n` goes low in the cycle after the edge that follows acceptance. It stays low for exactly WRITE_CLKS clocks (default 64).
- R6: While a store runs, `hold` is high and `frame_ready` is low. A frame offered in that time changes no live setting and no store entry.
- R7: When a write cycle ends, the store entry and the live setting of the addressed channel both take the new value on the same edge.
- R8: If `supply_ok` is low on the request edge, no store starts and `rdy_busy_n` stays high.
- R9: If `supply_ok` falls during a store, `rdy_busy_n` goes high at once. The cycle ends on the next edge, and the old stored value is kept.
- R10: Store entries survive a `rst_n` pulse that has no power-on reset. The reload after that pulse shows the values last committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; every step of the sequencer advances on its rising edge |
| por_n | input | 1 | Power-on reset, active low, asynchronous; fills the store with INIT_CODE |
| rst_n | input | 1 | Logic reset, active low, asynchronous; its release starts the live reload |
| frame_start | input | 1 | Start bit of a frame seen by the front end; opens the program window |
| prog_en | input | 1 | Program-enable line |
| supply_ok | input | 1 | Supply high enough for programming |
| frame_valid | input | 1 | A complete frame is offered |
| frame_addr | input | 2 | Channel address of the offered frame |
| frame_data | input | 8 | Setting carried by the offered frame |
| frame_ready | output | 1 | Block can take a frame |
| rdy_busy_n | output | 1 | Ready/busy flag, low while a store runs and supply is good |
| hold | output | 1 | Front end must ignore its data input and keep its data output idle |
| live_codes | output | 32 | Live setting of every channel, packed per channel |

## Verification
The hardest case to reach is a supply drop partway through a write cycle. The abort must leave the old entry in place, and that entry can only be seen through a later reload. The stimulus lowers `supply_ok` at a chosen count inside the busy window. It then pulses `rst_n` alone and compares the reloaded live settings with the value committed earlier. A second hard case is a frame arriving during a store. The bench offers one to a different channel while the flag is low and later checks that channel's live setting and store entry. The edges of the program window are driven directly: the request is raised only before the start edge, only on the edge after acceptance, and one edge too late.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  // width of a down counter that must hold values 0..n
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/nvs_window.sv
module nvs_window #(
  parameter int AW       = 2,
  parameter int DW       = 8,
  parameter int GAP_CLKS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_en,
  input  logic          frame_start,
  input  logic          prog_en,
  input  logic          frame_valid,
  input  logic [AW-1:0] frame_addr,
  input  logic [DW-1:0] frame_data,
  output logic          frame_ready,
  output logic          req_valid,
  output logic [AW-1:0] req_addr,
  output logic [DW-1:0] req_data
);
  localparam int GW = nvs_pkg::cnt_width(GAP_CLKS);

  logic          win_q, armed_q, first_q;
  logic [GW-1:0] gap_q;
  logic [AW-1:0] pend_addr_q;
  logic [DW-1:0] pend_data_q;
  logic          accept;

  assign frame_ready = accept_en && (gap_q == '0);
  assign accept      = frame_valid && frame_ready;
  // decision taken on the edge that follows acceptance
  assign req_valid   = first_q && (armed_q || (win_q && prog_en));
  assign req_addr    = pend_addr_q;
  assign req_data    = pend_data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q       <= 1'b0;
      armed_q     <= 1'b0;
      first_q     <= 1'b0;
      gap_q       <= '0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else begin
      first_q <= accept;
      if (accept) begin
        pend_addr_q <= frame_addr;
        pend_data_q <= frame_data;
        gap_q       <= GW'(GAP_CLKS);
      end else if (gap_q != '0) begin
        gap_q <= gap_q - 1'b1;
      end
      if (frame_start && frame_ready) begin
        win_q   <= 1'b1;
        armed_q <= 1'b0;
      end else if (first_q) begin
        win_q   <= 1'b0;
        armed_q <= 1'b0;
      end else if (win_q && prog_en) begin
        armed_q <= 1'b1;
      end
    end
  end

  // R4
  gap_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && frame_ready) |=> !frame_ready);

  // R2
  req_needs_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (win_q && $past(accept)));
endmodule

// File: rtl/nvs_write_timer.sv
module nvs_write_timer #(
  parameter int AW         = 2,
  parameter int DW         = 8,
  parameter int WRITE_CLKS = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          supply_ok,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          busy,
  output logic          rdy_busy_n,
  output logic          commit,
  output logic [AW-1:0] commit_addr,
  output logic [DW-1:0] commit_data
);
  localparam int CW = nvs_pkg::cnt_width(WRITE_CLKS);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  assign busy        = busy_q;
  assign rdy_busy_n  = !(busy_q && supply_ok);
  assign commit      = busy_q && supply_ok && (cnt_q == '0);
  assign commit_addr = addr_q;
  assign commit_data = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (!busy_q) begin
      if (req_valid && supply_ok) begin
        busy_q <= 1'b1;
        cnt_q  <= CW'(WRITE_CLKS - 1);
        addr_q <= req_addr;
        data_q <= req_data;
      end
    end else if (!supply_ok) begin
      busy_q <= 1'b0;
    end else if (cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R9
  abort_on_low_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !supply_ok) |=> !busy_q);

  // R8
  start_needs_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |-> $past(req_valid && supply_ok));
endmodule

// File: rtl/nvs_store.sv
module nvs_store #(
  parameter int          NUM_CH    = 4,
  parameter int          AW        = 2,
  parameter int          DW        = 8,
  parameter logic [7:0]  INIT_CODE = 8'h80
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [AW-1:0]        wr_addr,
  input  logic [DW-1:0]        wr_data,
  output logic                 loading,
  output logic [NUM_CH*DW-1:0] live_codes
);
  localparam int IW = nvs_pkg::cnt_width(NUM_CH);

  logic [DW-1:0] mem_q  [NUM_CH];
  logic [DW-1:0] live_q [NUM_CH];
  logic [IW-1:0] idx_q;
  logic          loading_q;

  assign loading = loading_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int i = 0; i < NUM_CH; i++) mem_q[i] <= DW'(INIT_CODE);
    end else if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loading_q <= 1'b1;
      idx_q     <= '0;
    end else if (loading_q) begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == IW'(NUM_CH - 1)) loading_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live_q[g] <= '0;
      end else if (loading_q && idx_q == IW'(g)) begin
        live_q[g] <= mem_q[g];
      end else if (wr_en && wr_addr == AW'(g)) begin
        live_q[g] <= wr_data;
      end
    end
    assign live_codes[g*DW +: DW] = live_q[g];

    // R6
    live_only_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!loading_q && !(wr_en && wr_addr == AW'(g))) |=> $stable(live_q[g]));
  end

  // R1
  load_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (loading_q && idx_q == IW'(NUM_CH - 1)) |=> !loading_q);
endmodule

// File: rtl/nv_store_seq.sv
module nv_store_seq #(
  parameter int         NUM_CH     = 4,
  parameter int         DW         = 8,
  parameter int         WRITE_CLKS = 64,
  parameter int         GAP_CLKS   = 2,
  parameter logic [7:0] INIT_CODE  = 8'h80,
  localparam int        AW         = (NUM_CH < 2) ? 1 : $clog2(NUM_CH)
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 rst_n,
  input  logic                 frame_start,
  input  logic                 prog_en,
  input  logic                 supply_ok,
  input  logic                 frame_valid,
  input  logic [AW-1:0]        frame_addr,
  input  logic [DW-1:0]        frame_data,
  output logic                 frame_ready,
  output logic                 rdy_busy_n,
  output logic                 hold,
  output logic [NUM_CH*DW-1:0] live_codes
);
  logic          busy, loading, req_valid, commit;
  logic [AW-1:0] req_addr, commit_addr;
  logic [DW-1:0] req_data, commit_data;

  assign hold = busy || loading;

  nvs_window #(.AW(AW), .DW(DW), .GAP_CLKS(GAP_CLKS)) u_window (
    .clk(clk), .rst_n(rst_n), .accept_en(!hold),
    .frame_start(frame_start), .prog_en(prog_en),
    .frame_valid(frame_valid), .frame_addr(frame_addr), .frame_data(frame_data),
    .frame_ready(frame_ready),
    .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data)
  );

  nvs_write_timer #(.AW(AW), .DW(DW), .WRITE_CLKS(WRITE_CLKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok),
    .req_valid(req_valid), .req_addr(req_addr), .req_data(req_data),
    .busy(busy), .rdy_busy_n(rdy_busy_n),
    .commit(commit), .commit_addr(commit_addr), .commit_data(commit_data)
  );

  nvs_store #(.NUM_CH(NUM_CH), .AW(AW), .DW(DW), .INIT_CODE(INIT_CODE)) u_store (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .wr_en(commit), .wr_addr(commit_addr), .wr_data(commit_data),
    .loading(loading), .live_codes(live_codes)
  );

  // R5
  busy_flag_implies_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rdy_busy_n |-> hold);

  // R6
  no_accept_in_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !frame_ready);
endmodule

// File: tb/tb_nv_store_seq.sv
module tb_nv_store_seq;
  localparam int NCH = 4;
  localparam int W   = 64;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0;
  logic frame_start = 1'b0, prog_en = 1'b0, supply_ok = 1'b1, frame_valid = 1'b0;
  logic [1:0] frame_addr = '0;
  logic [7:0] frame_data = '0;
  logic frame_ready, rdy_busy_n, hold;
  logic [NCH*8-1:0] live_codes;

  int nvec = 0, nerr = 0;
  logic [7:0] exp_store [NCH];

  always #4 clk = ~clk;

  nv_store_seq #(.NUM_CH(NCH), .DW(8), .WRITE_CLKS(W), .GAP_CLKS(2), .INIT_CODE(8'h80)) dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .frame_start(frame_start),
    .prog_en(prog_en), .supply_ok(supply_ok), .frame_valid(frame_valid),
    .frame_addr(frame_addr), .frame_data(frame_data), .frame_ready(frame_ready),
    .rdy_busy_n(rdy_busy_n), .hold(hold), .live_codes(live_codes)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] live_of(input int ch);
    return live_codes[ch*8 +: 8];
  endfunction

  // modes: 0 none, 1 held through window, 2 only on edge after accept,
  //        3 only before start edge, 4 first on second edge after accept
  function automatic bit expect_store(input int mode, input bit sup);
    return (mode == 1 || mode == 2) && sup;
  endfunction

  task automatic check_all_live(input string req);
    for (int c = 0; c < NCH; c++)
      check(live_of(c) == exp_store[c], req, live_of(c), exp_store[c]);
  endtask

  task automatic do_reset(input bit por);
    @(negedge clk);
    rst_n = 1'b0;
    if (por) por_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1; por_n = 1'b1;
    if (por) for (int c = 0; c < NCH; c++) exp_store[c] = 8'h80;
    #1;
    for (int k = 0; k < NCH; k++) begin
      check(hold == 1'b1, "R1 hold during reload", hold, 1);
      @(negedge clk); #1;
    end
    check(hold == 1'b0, "R1 hold after reload", hold, 0);
    check_all_live(por ? "R1 reload" : "R10 reload");
  endtask

  // abort_at: busy sample count at which supply drops (0 = never)
  // poke: offer a frame to channel addr^1 during the store
  task automatic send_frame(input logic [1:0] a, input logic [7:0] d, input int mode,
                            input bit sup, input int abort_at, input bit poke);
    bit st;
    int cnt;
    logic [7:0] other_before;
    st = expect_store(mode, sup);
    @(negedge clk);
    frame_start = 1'b1; prog_en = (mode == 3);
    @(negedge clk);
    frame_start = 1'b0; prog_en = (mode == 1);
    repeat (2) @(negedge clk);
    frame_valid = 1'b1; frame_addr = a; frame_data = d;
    @(negedge clk);
    frame_valid = 1'b0; prog_en = (mode == 1 || mode == 2); supply_ok = sup;
    #1 check(frame_ready == 1'b0, "R4 gap first cycle", frame_ready, 0);
    @(negedge clk);
    prog_en = (mode == 4); supply_ok = 1'b1;
    #1 check(rdy_busy_n == !st, st ? "R5 flag falls" : (sup ? "R3 no store" : "R8 low supply"),
             rdy_busy_n, !st);
    check(frame_ready == 1'b0, "R4 gap second cycle", frame_ready, 0);
    if (st) begin
      cnt = 0;
      other_before = live_of(a ^ 2'd1);
      while (rdy_busy_n == 1'b0 && cnt < 4 * W) begin
        cnt++;
        if (poke && cnt == 5) begin
          check(frame_ready == 1'b0 && hold == 1'b1, "R6 not ready while busy", frame_ready, 0);
          frame_valid = 1'b1; frame_addr = a ^ 2'd1; frame_data = ~exp_store[a ^ 2'd1];
        end else begin
          frame_valid = 1'b0;
        end
        if (abort_at != 0 && cnt == abort_at) begin
          supply_ok = 1'b0;
          #1 check(rdy_busy_n == 1'b1, "R9 flag high on drop", rdy_busy_n, 1);
          @(negedge clk);
          supply_ok = 1'b1;
          #1 check(hold == 1'b0, "R9 cycle ended", hold, 0);
          break;
        end
        prog_en = 1'b0;
        @(negedge clk); #1;
      end
      frame_valid = 1'b0;
      if (abort_at == 0) begin
        check(cnt == W, "R5 busy length", cnt, W);
        exp_store[a] = d;
        check(live_of(a) == d, "R7 live updated", live_of(a), d);
      end else begin
        check(live_of(a) == exp_store[a], "R9 live kept", live_of(a), exp_store[a]);
      end
      if (poke)
        check(live_of(a ^ 2'd1) == other_before, "R6 frame ignored",
              live_of(a ^ 2'd1), other_before);
      check(frame_ready == 1'b1, "R4 ready after store", frame_ready, 1);
    end else begin
      @(negedge clk);
      prog_en = 1'b0;
      #1 check(frame_ready == 1'b1, "R4 ready after gap", frame_ready, 1);
      check(rdy_busy_n == 1'b1, "R3 late request ignored", rdy_busy_n, 1);
      check(live_of(a) == exp_store[a], "R3 value discarded", live_of(a), exp_store[a]);
    end
    @(negedge clk);
  endtask

  bit done = 1'b0;

  initial begin
    int seed;
    seed = $urandom(32'd515);
    do_reset(1'b1);
    send_frame(2'd1, 8'h3C, 1, 1'b1, 0, 1'b0);  // R2 held through window
    send_frame(2'd2, 8'hA5, 2, 1'b1, 0, 1'b0);  // R2 edge after acceptance
    send_frame(2'd3, 8'h11, 3, 1'b1, 0, 1'b0);  // R3 before start edge
    send_frame(2'd3, 8'h22, 4, 1'b1, 0, 1'b0);  // R3 one edge late
    send_frame(2'd0, 8'h77, 0, 1'b1, 0, 1'b0);  // R3 no request
    send_frame(2'd0, 8'h5A, 1, 1'b0, 0, 1'b0);  // R8 low supply
    send_frame(2'd2, 8'hFF, 1, 1'b1, 0, 1'b1);  // R6 frame during store
    send_frame(2'd1, 8'h00, 2, 1'b1, 20, 1'b0); // R9 abort
    do_reset(1'b0);                             // R10 entries survive
    for (int n = 0; n < 24; n++) begin
      send_frame(2'($urandom_range(0, 3)), 8'($urandom_range(0, 255)),
                 $urandom_range(0, 4), ($urandom_range(0, 5) != 0), 0,
                 ($urandom_range(0, 3) == 0));
    end
    do_reset(1'b0);                             // R10 after random stores
    do_reset(1'b1);                             // R1 power-on default again
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nvec++; nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule